// File: doc/BRIEF.md
# Crossbar Slave FIFO Bridge

This block answers transactions that a remote master opens on a circuit-switched crossbar port. It moves data words between that port and a pair of local FIFOs. The first valid word of a transaction is a route header and the second is an address header. Bit 1 of the address header selects the direction. In a write, the remote side sends words and the block streams them into the output FIFO. In a read, the remote side pulls words and the block fetches each one from the input FIFO.

Flow control differs by direction. When the output FIFO reports almost full during a write, the block asks the master to kill the transaction. When the input FIFO reports almost empty during a read, the block also asks for a kill. It then stops touching the input FIFO for the rest of that transaction, returns zero words for any further pulls, and sends an error reply once the master ends the transfer. The FIFO data bus is modelled as a data register plus a drive enable, so three-stating is explicit.

Top module: `xbar_slave_bridge`

## Requirements
- R1: Bit 1 of the address header word selects the direction: 0 is a write into the output FIFO (the FIFO bus drive enable goes high), 1 is a read from the input FIFO (the drive enable stays low).
- R2: Neither the route header nor the address header is ever written into the output FIFO (no write strobe follows either one).
- R3: In a write, every valid data word gives exactly one output-FIFO write strobe in the next cycle, with that word on the FIFO data out and the drive enable high.
- R4: In a write, while output-FIFO almost-full is high, the reply code is kill (2'b01).
- R5: In a read, each valid word from the master is a pull request. The block pulses input-FIFO read enable in the next cycle and output enable in the cycle after that, captures the FIFO data during the output-enable cycle, and presents it with a one-cycle reply-valid in the next cycle. The drive enable stays low.
- R6: If input-FIFO almost-empty is high when a pull arrives, no read enable is issued for that pull or any later pull of the transaction. Each such pull returns a zero word, and the reply code stays kill (2'b01) until the transaction ends.
- R7: After a read in which an underflow happened, the reply code is error (2'b10) for exactly the one cycle after the end-of-transaction strobe. Without an underflow it stays none (2'b00).
- R8: The slave status is high from the cycle after the route header until the end strobe is taken. After the end strobe, the status and the FIFO drive enable are low.
- R9: A local master-start request while a slave transaction is open gives the kill reply (2'b01). While idle it has no effect on the reply.
- R10: After reset, the status, all FIFO strobes, the drive enable and reply-valid are low, and the reply code is none (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xb_valid_i | input | 1 | Word strobe from the remote master |
| xb_data_i | input | DW | Word from the remote master |
| xb_end_i | input | 1 | End-of-transaction strobe |
| xb_rdata_o | output | DW | Word returned to the master on a read |
| xb_rvalid_o | output | 1 | Returned word valid |
| xb_reply_o | output | 2 | Reply code: 00 none, 01 kill, 10 error |
| ofifo_data_o | output | DW | Output-FIFO data bus value |
| ofifo_drive_o | output | 1 | FIFO data bus drive enable |
| ofifo_we_o | output | 1 | Output-FIFO write strobe |
| ofifo_af_i | input | 1 | Output-FIFO almost full |
| ififo_data_i | input | DW | Input-FIFO data bus value |
| ififo_re_o | output | 1 | Input-FIFO read enable |
| ififo_oe_o | output | 1 | Input-FIFO output enable |
| ififo_ae_i | input | 1 | Input-FIFO almost empty |
| mst_start_i | input | 1 | Local master-start request |
| slave_o | output | 1 | Slave transaction in progress |

## Verification
A table of transactions covers clean writes and reads of several lengths, a write that hits almost-full partway through, and a read that underflows partway through. These show that direction follows the address bit, and that the kill behaviour differs by direction. In the underflowing read, pulls made after the almost-empty flag has dropped again show that the suppression is sticky and not a live gate. Directed cases cover reset values, the master-start request while idle and while busy, a transaction that ends after only its route header, and an address word whose other bits are all set, which shows that bit 1 alone decides the direction.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} xbs_state_e;
  typedef enum logic [1:0] {F_IDLE, F_RE, F_OE} xbs_fetch_e;
  typedef enum logic [1:0] {RPL_NONE = 2'b00, RPL_KILL = 2'b01, RPL_ERR = 2'b10} xbs_reply_e;
endpackage

// File: rtl/xbs_ctrl.sv
module xbs_ctrl
  import xbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       dir_bit_i,
  input  logic       end_i,
  output xbs_state_e state_o
);
  xbs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (valid_i) state_d = S_ADDR;
      S_ADDR: if (valid_i) state_d = dir_bit_i ? S_RD : S_WR;
      default: ;
    endcase
    if (end_i && state_q != S_IDLE) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/xbs_wr_path.sv
module xbs_wr_path #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] fdata_o,
  output logic          we_o,
  output logic          drive_o
);
  logic          we_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      we_q <= active_i & valid_i;
      if (active_i && valid_i) data_q <= data_i;
    end
  end

  assign fdata_o = data_q;
  assign we_o    = we_q;
  // keep driving while the last word is still being written
  assign drive_o = active_i | we_q;
endmodule

// File: rtl/xbs_rd_fetch.sv
module xbs_rd_fetch
  import xbs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          req_i,
  input  logic          ae_i,
  input  logic [DW-1:0] fdata_i,
  output logic          re_o,
  output logic          oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          uflow_o
);
  xbs_fetch_e    phase_q;
  logic          rvalid_q, uflow_q;
  logic [DW-1:0] rdata_q;
  logic          take;

  assign take = active_i & req_i & (phase_q == F_IDLE) & ~rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= F_IDLE;
      rvalid_q <= 1'b0;
      uflow_q  <= 1'b0;
      rdata_q  <= '0;
    end else if (!active_i) begin
      phase_q  <= F_IDLE;
      rvalid_q <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (phase_q)
        F_IDLE: if (take) begin
          if (uflow_q || ae_i) begin
            uflow_q  <= 1'b1;
            rdata_q  <= '0;
            rvalid_q <= 1'b1;
          end else begin
            phase_q <= F_RE;
          end
        end
        F_RE: phase_q <= F_OE;
        F_OE: begin
          rdata_q  <= fdata_i;
          rvalid_q <= 1'b1;
          phase_q  <= F_IDLE;
        end
        default: phase_q <= F_IDLE;
      endcase
    end
  end

  assign re_o     = active_i & (phase_q == F_RE);
  assign oe_o     = active_i & (phase_q == F_OE);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign uflow_o  = uflow_q;
endmodule

// File: rtl/xbar_slave_bridge.sv
module xbar_slave_bridge
  import xbs_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DIR_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xb_valid_i,
  input  logic [DW-1:0] xb_data_i,
  input  logic          xb_end_i,
  output logic [DW-1:0] xb_rdata_o,
  output logic          xb_rvalid_o,
  output logic [1:0]    xb_reply_o,
  output logic [DW-1:0] ofifo_data_o,
  output logic          ofifo_drive_o,
  output logic          ofifo_we_o,
  input  logic          ofifo_af_i,
  input  logic [DW-1:0] ififo_data_i,
  output logic          ififo_re_o,
  output logic          ififo_oe_o,
  input  logic          ififo_ae_i,
  input  logic          mst_start_i,
  output logic          slave_o
);
  xbs_state_e state;
  logic       wr_act, rd_act, uflow, kill, err_q;

  xbs_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (xb_valid_i),
    .dir_bit_i (xb_data_i[DIR_BIT]),
    .end_i     (xb_end_i),
    .state_o   (state)
  );

  assign wr_act  = (state == S_WR);
  assign rd_act  = (state == S_RD);
  assign slave_o = (state != S_IDLE);

  xbs_wr_path #(.DW(DW)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(wr_act),
    .valid_i (xb_valid_i),
    .data_i  (xb_data_i),
    .fdata_o (ofifo_data_o),
    .we_o    (ofifo_we_o),
    .drive_o (ofifo_drive_o)
  );

  xbs_rd_fetch #(.DW(DW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(rd_act),
    .req_i   (xb_valid_i),
    .ae_i    (ififo_ae_i),
    .fdata_i (ififo_data_i),
    .re_o    (ififo_re_o),
    .oe_o    (ififo_oe_o),
    .rdata_o (xb_rdata_o),
    .rvalid_o(xb_rvalid_o),
    .uflow_o (uflow)
  );

  // error is reported once, in the cycle after completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= rd_act & xb_end_i & uflow;
  end

  assign kill = slave_o & ((wr_act & ofifo_af_i) | uflow | mst_start_i);

  always_comb begin
    if (err_q)     xb_reply_o = RPL_ERR;
    else if (kill) xb_reply_o = RPL_KILL;
    else           xb_reply_o = RPL_NONE;
  end
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xb_end_i,
  input logic [1:0] xb_reply_o,
  input logic       ofifo_drive_o,
  input logic       ofifo_we_o,
  input logic       ififo_re_o,
  input logic       ififo_oe_o,
  input logic       mst_start_i,
  input logic       slave_o
);
  a_r5_oe_follows_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ififo_re_o |=> (ififo_oe_o || !slave_o));

  a_r5_re_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ififo_re_o && ififo_oe_o));

  a_r5_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ififo_re_o || ififo_oe_o) |-> !ofifo_drive_o);

  a_r3_we_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofifo_we_o |-> ofifo_drive_o);

  a_r7_err_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xb_reply_o == 2'b10) |-> ($past(xb_end_i) && !slave_o));

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xb_reply_o == 2'b10) |=> (xb_reply_o != 2'b10));

  a_r9_start_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_o && mst_start_i) |-> (xb_reply_o == 2'b01));

  a_r8_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_o |-> !(ififo_re_o || ififo_oe_o));
endmodule

bind xbar_slave_bridge xbs_checker u_chk (.*);

// File: tb/xbar_slave_bridge_tb_top.sv
module xbar_slave_bridge_tb_top;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          xb_valid_i = 1'b0;
  logic [DW-1:0] xb_data_i = '0;
  logic          xb_end_i = 1'b0;
  logic [DW-1:0] xb_rdata_o;
  logic          xb_rvalid_o;
  logic [1:0]    xb_reply_o;
  logic [DW-1:0] ofifo_data_o;
  logic          ofifo_drive_o, ofifo_we_o;
  logic          ofifo_af_i = 1'b0;
  logic [DW-1:0] ififo_data_i = '0;
  logic          ififo_re_o, ififo_oe_o;
  logic          ififo_ae_i = 1'b0;
  logic          mst_start_i = 1'b0;
  logic          slave_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xbar_slave_bridge #(.DW(DW)) dut_i (.*);

  // {read, words[2:0], fault index (4'hF none), seed}
  localparam logic [39:0] TXN [4] = '{
    {1'b0, 3'd4, 4'hF, 32'h1111_0000},
    {1'b0, 3'd3, 4'd1, 32'h2222_0100},
    {1'b1, 3'd4, 4'hF, 32'h3333_0200},
    {1'b1, 3'd5, 4'd2, 32'h4444_0300}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    xb_valid_i = 1'b1;
    xb_data_i  = w;
    @(negedge clk_i);
    xb_valid_i = 1'b0;
  endtask

  task automatic finish_txn(input logic [1:0] exp_reply);
    xb_end_i = 1'b1;
    @(negedge clk_i);
    xb_end_i = 1'b0;
    chk("R8 slave low after end", 32'(slave_o), 0);
    chk("R7 reply after end", 32'(xb_reply_o), 32'(exp_reply));
    @(negedge clk_i);
    chk("R8 drive off after end", 32'(ofifo_drive_o), 0);
    chk("R7 reply back to none", 32'(xb_reply_o), 0);
  endtask

  task automatic write_txn(input int n, input logic [31:0] seed, input int fault, input logic [31:0] addr);
    send(32'hA5A5_0001);
    chk("R8 slave high after route", 32'(slave_o), 1);
    chk("R2 route not written", 32'(ofifo_we_o), 0);
    send(addr);
    chk("R2 address not written", 32'(ofifo_we_o), 0);
    chk("R1 write drives bus", 32'(ofifo_drive_o), 1);
    for (int k = 0; k < n; k++) begin
      send(seed + 32'(k));
      chk("R3 write strobe", 32'(ofifo_we_o), 1);
      chk("R3 write data", ofifo_data_o, seed + 32'(k));
      chk("R3 drive on", 32'(ofifo_drive_o), 1);
      if (k == fault) begin
        ofifo_af_i = 1'b1;
        #1 chk("R4 almost full kills", 32'(xb_reply_o), 1);
        @(negedge clk_i);
        ofifo_af_i = 1'b0;
        #1 chk("R4 kill drops with flag", 32'(xb_reply_o), 0);
      end else begin
        @(negedge clk_i);
        chk("R3 single strobe", 32'(ofifo_we_o), 0);
      end
    end
    finish_txn(2'b00);
  endtask

  task automatic read_txn(input int n, input logic [31:0] seed, input int fault);
    send(32'hA5A5_0002);
    send(32'h0000_0002);
    chk("R1 read leaves bus undriven", 32'(ofifo_drive_o), 0);
    for (int k = 0; k < n; k++) begin
      if (k == fault) ififo_ae_i = 1'b1;
      send(32'h0);
      ififo_ae_i = 1'b0;
      if (k >= fault) begin
        chk("R6 no read after underflow", 32'(ififo_re_o), 0);
        chk("R6 zero word valid", 32'(xb_rvalid_o), 1);
        chk("R6 zero word", xb_rdata_o, 0);
        chk("R6 kill after underflow", 32'(xb_reply_o), 1);
      end else begin
        chk("R5 read enable first", 32'(ififo_re_o), 1);
        chk("R5 no output enable yet", 32'(ififo_oe_o), 0);
        @(negedge clk_i);
        chk("R5 output enable second", 32'(ififo_oe_o), 1);
        chk("R5 read enable dropped", 32'(ififo_re_o), 0);
        chk("R5 bus undriven", 32'(ofifo_drive_o), 0);
        ififo_data_i = seed + 32'(k);
        @(negedge clk_i);
        chk("R5 word valid", 32'(xb_rvalid_o), 1);
        chk("R5 word value", xb_rdata_o, seed + 32'(k));
        chk("R5 no kill on clean read", 32'(xb_reply_o), 0);
      end
      @(negedge clk_i);
      chk("R6 no strobes between pulls", 32'(ififo_re_o | xb_rvalid_o), 0);
    end
    finish_txn(fault < n ? 2'b10 : 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 slave", 32'(slave_o), 0);
    chk("R10 strobes", 32'({ofifo_we_o, ififo_re_o, ififo_oe_o, xb_rvalid_o}), 0);
    chk("R10 drive", 32'(ofifo_drive_o), 0);
    chk("R10 reply", 32'(xb_reply_o), 0);

    for (int i = 0; i < 4; i++) begin
      if (TXN[i][39])
        read_txn(int'(TXN[i][38:36]), TXN[i][31:0], TXN[i][35:32] == 4'hF ? 99 : int'(TXN[i][35:32]));
      else
        write_txn(int'(TXN[i][38:36]), TXN[i][31:0], TXN[i][35:32] == 4'hF ? 99 : int'(TXN[i][35:32]), 32'h0000_1000);
      repeat (2) @(negedge clk_i);
    end

    mst_start_i = 1'b1;
    #1 chk("R9 start while idle ignored", 32'(xb_reply_o), 0);
    @(negedge clk_i);
    mst_start_i = 1'b0;

    send(32'hA5A5_0003);
    mst_start_i = 1'b1;
    #1 chk("R9 start while busy kills", 32'(xb_reply_o), 1);
    @(negedge clk_i);
    mst_start_i = 1'b0;
    finish_txn(2'b00);

    write_txn(1, 32'h5555_0000, 99, 32'hFFFF_FFFD);

    ofifo_af_i = 1'b1;
    send(32'hA5A5_0004);
    #1 chk("R4 almost full ignored in header", 32'(xb_reply_o), 0);
    ofifo_af_i = 1'b0;
    finish_txn(2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule